// File: doc/BRIEF.md
# Dataflow Operand Matching Unit

This block is the operand pairing stage of a dataflow engine that keeps its waiting operands in per-activation frame memory. Each arriving token names an instruction, an activation frame, a data value and the input side (left or right) it belongs to. The unit reads the named instruction from a small program store. The instruction gives an operation, an offset into the frame and at most two successor instructions. The unit then looks at the frame slot at frame base plus offset. If an operand is already waiting in that slot, the two values are ordered by side and combined, the slot is freed, and one result token goes to each successor. If the slot is empty, the arriving value is parked there and nothing is emitted.

Single-input instructions skip the frame and fire at once. Result tokens queue in a small output buffer that drains through a valid/ready handshake. The unit takes in a new token only when it can place every result of the token it is currently holding. The program store is filled from a parameter constant on every reset.

Top module: `tok_match_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is low and `in_ready` is high. Reset empties every frame slot, so a token that reaches a slot parked before reset is parked again.
- R2: An instruction word is 23 bits: operation in [2:0], frame offset in [8:3], successor count in [10:9], first successor instruction in [15:11] and its side in [16], second successor instruction in [21:17] and its side in [22]. The slot used is (frame base + offset) modulo 64.
- R3: A two-input token that finds its slot empty writes its value and side into the slot, marks the slot present and emits no token.
- R4: A two-input token that finds its slot present fires the instruction and marks the slot empty, so the next token for that slot is parked.
- R5: Side 0 means left and side 1 means right. When the waiting operand is right and the arriving one is left, the arriving value is the left operand. In every other case, including equal sides, the waiting value is the left operand.
- R6: Two-input operations: 0 gives left+right, 1 gives left-right, 2 gives the low 16 bits of left*right, 3 gives left AND right.
- R7: Operations 4 to 7 take one input and fire on arrival: 4 passes the value, 5 negates it (two's complement), 6 adds one, 7 inverts every bit. They neither read nor change any frame slot.
- R8: A firing instruction emits one token per successor: the first successor, then the second. Each token carries that successor's instruction, that successor's side, the computed value and the incoming frame base. A count of 0 emits nothing, and a count of 3 acts as 2.
- R9: The output buffer holds 4 tokens. While `out_valid` is high and `out_ready` is low, the output token stays unchanged. A held token whose results do not fit in the free space waits, and `in_ready` stays low until they fit.
- R10: A token is taken in on each clock edge where `in_valid` and `in_ready` are both high. At most one token is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input token present |
| in_ip | input | 5 | Instruction addressed by the input token |
| in_fbase | input | 6 | Frame base of the input token |
| in_port | input | 1 | Input side, 0 left, 1 right |
| in_value | input | 16 | Operand value |
| in_ready | output | 1 | Unit takes the input token at this edge |
| out_valid | output | 1 | Result token present |
| out_ready | input | 1 | Consumer takes the result token |
| out_ip | output | 5 | Successor instruction of the result token |
| out_fbase | output | 6 | Frame base of the result token |
| out_port | output | 1 | Successor input side |
| out_value | output | 16 | Result value |

## Verification
The properties assume the producer follows the valid/ready handshake. Once `in_valid` is raised, the token stays on the inputs unchanged until an edge where `in_ready` is high; a separate property checks that assumption. The bench drives every token through one task that holds the fields steady and drops `in_valid` only after the accepting edge. The properties also assume that only the matching stage writes the frame, so each presence-bit change is traced to the token that caused it. The bench's successor tokens are never fed back, so every frame write comes from stimulus the bench chose.

// File: rtl/tm_pkg.sv
package tm_pkg;

    localparam int IP_W    = 5;
    localparam int FB_W    = 6;
    localparam int DATA_W  = 16;
    localparam int OP_W    = 3;
    localparam int DC_W    = 2;
    localparam int IMEM_N  = 1 << IP_W;
    localparam int FRAME_N = 1 << FB_W;
    localparam int MAX_DST = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_AND  = 3'd3,
        OP_PASS = 3'd4,
        OP_NEG  = 3'd5,
        OP_INC  = 3'd6,
        OP_NOT  = 3'd7
    } op_e;

    // Listed MSB first: the operation lands in the low bits of the word.
    typedef struct packed {
        logic            d1_port;
        logic [IP_W-1:0] d1_ip;
        logic            d0_port;
        logic [IP_W-1:0] d0_ip;
        logic [DC_W-1:0] dcount;
        logic [FB_W-1:0] offset;
        op_e             op;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef struct packed {
        logic [IP_W-1:0]   ip;
        logic [FB_W-1:0]   fbase;
        logic              port;
        logic [DATA_W-1:0] value;
    } token_t;

    typedef struct packed {
        logic              present;
        logic              port;
        logic [DATA_W-1:0] value;
    } slot_t;

    // Default program: a chain of pass-through instructions.
    function automatic logic [IMEM_N*INSTR_W-1:0] default_prog();
        logic [IMEM_N*INSTR_W-1:0] p;
        instr_t w;
        p = '0;
        for (int i = 0; i < IMEM_N; i++) begin
            w         = '0;
            w.op      = OP_PASS;
            w.dcount  = DC_W'(1);
            w.d0_ip   = IP_W'((i + 1) % IMEM_N);
            p[i*INSTR_W +: INSTR_W] = w;
        end
        return p;
    endfunction

endpackage

// File: rtl/tm_imem.sv
module tm_imem
    import tm_pkg::*;
#(
    parameter logic [IMEM_N*INSTR_W-1:0] INIT = default_prog()
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IP_W-1:0] rd_addr,
    output instr_t          rd_data
);

    instr_t mem_d [IMEM_N];
    instr_t mem_q [IMEM_N];

    always_comb begin
        for (int i = 0; i < IMEM_N; i++) begin
            mem_d[i] = mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < IMEM_N; i++) begin
                mem_q[i] <= instr_t'(INIT[i*INSTR_W +: INSTR_W]);
            end
        end else begin
            for (int i = 0; i < IMEM_N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/tm_frame_store.sv
module tm_frame_store
    import tm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FB_W-1:0]    rd_addr,
    output slot_t              rd_slot,
    input  logic               wr_en,
    input  logic [FB_W-1:0]    wr_addr,
    input  slot_t              wr_slot,
    output logic [FRAME_N-1:0] present_vec
);

    slot_t mem_d [FRAME_N];
    slot_t mem_q [FRAME_N];

    always_comb begin
        for (int i = 0; i < FRAME_N; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FRAME_N; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < FRAME_N; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_slot = mem_q[rd_addr];

    for (genvar g = 0; g < FRAME_N; g++) begin : g_pres
        assign present_vec[g] = mem_q[g].present;
    end

endmodule

// File: rtl/tm_alu.sv
module tm_alu
    import tm_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        unique case (op)
            OP_ADD:  result = left + right;
            OP_SUB:  result = left - right;
            OP_MUL:  result = left * right;
            OP_AND:  result = left & right;
            OP_PASS: result = left;
            OP_NEG:  result = DATA_W'(0) - left;
            OP_INC:  result = left + DATA_W'(1);
            OP_NOT:  result = ~left;
            default: result = left;
        endcase
    end

endmodule

// File: rtl/tm_out_fifo.sv
module tm_out_fifo
    import tm_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       push_n,
    input  token_t           push0,
    input  token_t           push1,
    input  logic             pop,
    output token_t           head,
    output logic             valid,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        token_t [DEPTH-1:0] slots;
        logic [PTR_W-1:0]   wr;
        logic [PTR_W-1:0]   rd;
        logic [CNT_W-1:0]   cnt;
    } fifo_st_t;

    fifo_st_t s_d;
    fifo_st_t s_q;
    logic     pop_ok;

    always_comb begin
        s_d    = s_q;
        pop_ok = pop && (s_q.cnt != '0);
        if (pop_ok) begin
            s_d.rd = s_q.rd + PTR_W'(1);
        end
        if (push_n != 2'd0) begin
            s_d.slots[s_q.wr] = push0;
        end
        if (push_n == 2'd2) begin
            s_d.slots[s_q.wr + PTR_W'(1)] = push1;
        end
        s_d.wr  = s_q.wr + PTR_W'(push_n);
        s_d.cnt = s_q.cnt + CNT_W'(push_n) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = s_q.slots[s_q.rd];
    assign valid = (s_q.cnt != '0);
    assign count = s_q.cnt;

endmodule

// File: rtl/tok_match_unit.sv
module tok_match_unit
    import tm_pkg::*;
#(
    parameter int OUT_DEPTH = 4,
    parameter logic [IMEM_N*INSTR_W-1:0] IMEM_INIT = default_prog()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IP_W-1:0]   in_ip,
    input  logic [FB_W-1:0]   in_fbase,
    input  logic              in_port,
    input  logic [DATA_W-1:0] in_value,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IP_W-1:0]   out_ip,
    output logic [FB_W-1:0]   out_fbase,
    output logic              out_port,
    output logic [DATA_W-1:0] out_value
);

    localparam int CNT_W = $clog2(OUT_DEPTH + 1);

    typedef struct packed {
        logic   busy;
        token_t tok;
    } stage_st_t;

    stage_st_t s_d;
    stage_st_t s_q;

    token_t               in_tok;
    instr_t               ins;
    slot_t                slot_rd;
    slot_t                slot_wr;
    logic [FB_W-1:0]      slot_addr;
    logic                 stage_busy;
    logic                 monadic;
    logic                 match;
    logic                 fire;
    logic                 done;
    logic                 swap;
    logic [1:0]           dests;
    logic [1:0]           need;
    logic [1:0]           push_n;
    logic [CNT_W-1:0]     fifo_cnt;
    logic [CNT_W-1:0]     fifo_free;
    logic [DATA_W-1:0]    opa;
    logic [DATA_W-1:0]    opb;
    logic [DATA_W-1:0]    result;
    logic [FRAME_N-1:0]   pres_vec;
    token_t               out_tok;
    token_t               dst_tok [MAX_DST];
    logic [IP_W-1:0]      dst_ip [MAX_DST];
    logic                 dst_port [MAX_DST];

    assign in_tok     = '{ip: in_ip, fbase: in_fbase, port: in_port, value: in_value};
    assign stage_busy = s_q.busy;

    tm_imem #(
        .INIT(IMEM_INIT)
    ) u_imem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (s_q.tok.ip),
        .rd_data (ins)
    );

    tm_frame_store u_frame (
        .clk         (clk),
        .rst         (rst),
        .rd_addr     (slot_addr),
        .rd_slot     (slot_rd),
        .wr_en       (done && !monadic),
        .wr_addr     (slot_addr),
        .wr_slot     (slot_wr),
        .present_vec (pres_vec)
    );

    tm_alu u_alu (
        .op     (ins.op),
        .left   (opa),
        .right  (opb),
        .result (result)
    );

    assign dst_ip[0]   = ins.d0_ip;
    assign dst_port[0] = ins.d0_port;
    assign dst_ip[1]   = ins.d1_ip;
    assign dst_port[1] = ins.d1_port;

    for (genvar g = 0; g < MAX_DST; g++) begin : g_dst
        assign dst_tok[g] = '{ip:    dst_ip[g],
                              fbase: s_q.tok.fbase,
                              port:  dst_port[g],
                              value: result};
    end

    tm_out_fifo #(
        .DEPTH(OUT_DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_n (push_n),
        .push0  (dst_tok[0]),
        .push1  (dst_tok[1]),
        .pop    (out_ready),
        .head   (out_tok),
        .valid  (out_valid),
        .count  (fifo_cnt)
    );

    always_comb begin
        s_d       = s_q;
        slot_addr = s_q.tok.fbase + ins.offset;
        monadic   = ins.op[OP_W-1];
        match     = !monadic && slot_rd.present;
        fire      = monadic || match;
        dests     = (ins.dcount > 2'd2) ? 2'd2 : ins.dcount;
        need      = fire ? dests : 2'd0;
        fifo_free = CNT_W'(OUT_DEPTH) - fifo_cnt;
        done      = s_q.busy && (CNT_W'(need) <= fifo_free);
        in_ready  = !s_q.busy || done;
        push_n    = done ? need : 2'd0;

        // Waiting right operand meets arriving left one: arrival goes first.
        swap = !s_q.tok.port && slot_rd.port;
        if (monadic) begin
            opa = s_q.tok.value;
            opb = '0;
        end else if (swap) begin
            opa = s_q.tok.value;
            opb = slot_rd.value;
        end else begin
            opa = slot_rd.value;
            opb = s_q.tok.value;
        end

        if (match) begin
            slot_wr = '0;
        end else begin
            slot_wr = '{present: 1'b1, port: s_q.tok.port, value: s_q.tok.value};
        end

        if (in_ready) begin
            s_d.busy = in_valid;
            s_d.tok  = in_tok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_ip    = out_tok.ip;
    assign out_fbase = out_tok.fbase;
    assign out_port  = out_tok.port;
    assign out_value = out_tok.value;

endmodule

// File: rtl/tm_checker.sv
module tm_checker
    import tm_pkg::*;
#(
    parameter int OUT_DEPTH = 4,
    localparam int CNT_W = $clog2(OUT_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input token_t             in_tok,
    input logic               out_valid,
    input logic               out_ready,
    input token_t             out_tok,
    input logic               stage_done,
    input logic               stage_match,
    input logic               stage_monadic,
    input logic [FB_W-1:0]    stage_addr,
    input logic [CNT_W-1:0]   fifo_cnt,
    input logic [FRAME_N-1:0] pres_vec
);

    p_park_sets_r3: assert property (@(posedge clk) disable iff (rst)
        stage_done && !stage_monadic && !stage_match |=> pres_vec[$past(stage_addr)])
        else $error("parked operand did not mark its slot present");

    p_park_silent_r3: assert property (@(posedge clk) disable iff (rst)
        stage_done && !stage_monadic && !stage_match && !(out_valid && out_ready)
        |=> fifo_cnt == $past(fifo_cnt))
        else $error("parked operand produced an output token");

    p_fire_clears_r4: assert property (@(posedge clk) disable iff (rst)
        stage_done && stage_match |=> !pres_vec[$past(stage_addr)])
        else $error("fired slot still present");

    p_monadic_frame_r7: assert property (@(posedge clk) disable iff (rst)
        stage_done && stage_monadic |=> pres_vec == $past(pres_vec))
        else $error("single-input instruction changed the frame");

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(OUT_DEPTH))
        else $error("output buffer count above depth");

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_tok))
        else $error("output token changed while stalled");

    p_in_hold_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_ready |=> in_valid && $stable(in_tok))
        else $error("producer changed a token that was not taken");

endmodule

bind tok_match_unit tm_checker #(
    .OUT_DEPTH(OUT_DEPTH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_tok        (in_tok),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_tok       (out_tok),
    .stage_done    (done),
    .stage_match   (match),
    .stage_monadic (monadic),
    .stage_addr    (slot_addr),
    .fifo_cnt      (fifo_cnt),
    .pres_vec      (pres_vec)
);

// File: tb/sim_tok_match_unit.sv
`timescale 1ns/1ps
module sim_tok_match_unit;
    import tm_pkg::*;

    function automatic instr_t enc(op_e op, int off, int dc, int i0, int p0, int i1, int p1);
        instr_t w;
        w.op      = op;
        w.offset  = FB_W'(off);
        w.dcount  = DC_W'(dc);
        w.d0_ip   = IP_W'(i0);
        w.d0_port = p0[0];
        w.d1_ip   = IP_W'(i1);
        w.d1_port = p1[0];
        return w;
    endfunction

    function automatic logic [IMEM_N*INSTR_W-1:0] build_prog();
        logic [IMEM_N*INSTR_W-1:0] p;
        p = '0;
        p[0*INSTR_W +: INSTR_W] = enc(OP_ADD,  0, 1,  5, 0,  0, 0);
        p[1*INSTR_W +: INSTR_W] = enc(OP_SUB,  1, 2,  6, 1,  7, 0);
        p[2*INSTR_W +: INSTR_W] = enc(OP_MUL,  2, 1,  8, 0,  0, 0);
        p[3*INSTR_W +: INSTR_W] = enc(OP_AND,  3, 1,  9, 1,  0, 0);
        p[4*INSTR_W +: INSTR_W] = enc(OP_PASS, 0, 2, 10, 0, 11, 1);
        p[5*INSTR_W +: INSTR_W] = enc(OP_NEG,  0, 1, 12, 0,  0, 0);
        p[6*INSTR_W +: INSTR_W] = enc(OP_INC,  0, 0,  0, 0,  0, 0);
        p[7*INSTR_W +: INSTR_W] = enc(OP_NOT,  0, 1, 13, 1,  0, 0);
        p[8*INSTR_W +: INSTR_W] = enc(OP_ADD, 63, 1, 14, 0,  0, 0);
        p[9*INSTR_W +: INSTR_W] = enc(OP_INC,  0, 3, 14, 0, 15, 1);
        return p;
    endfunction

    localparam logic [IMEM_N*INSTR_W-1:0] PROG = build_prog();

    typedef struct packed {
        int req; int ip; int fb; int port; int val; int n;
        int a_ip; int a_port; int a_val; int b_ip; int b_port; int b_val;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{3, 0, 0, 1, 7,      0, 0, 0, 0,      0, 0, 0},      // R3 park slot 0
        '{6, 0, 0, 0, 5,      1, 5, 0, 12,     0, 0, 0},      // R6 add fires
        '{3, 1, 0, 0, 20,     0, 0, 0, 0,      0, 0, 0},      // R3 park slot 1
        '{8, 1, 0, 1, 3,      2, 6, 1, 17,     7, 0, 17},     // R8 two successors
        '{2, 1, 4, 1, 3,      0, 0, 0, 0,      0, 0, 0},      // R2 slot 5
        '{5, 1, 4, 0, 20,     2, 6, 1, 17,     7, 0, 17},     // R5 arrival is left
        '{3, 2, 0, 0, 256,    0, 0, 0, 0,      0, 0, 0},      // R3
        '{6, 2, 0, 1, 768,    1, 8, 0, 0,      0, 0, 0},      // R6 mul wraps to 0
        '{3, 2, 0, 0, 291,    0, 0, 0, 0,      0, 0, 0},      // R3
        '{6, 2, 0, 1, 16,     1, 8, 0, 4656,   0, 0, 0},      // R6 mul low
        '{3, 3, 0, 1, 61680,  0, 0, 0, 0,      0, 0, 0},      // R3
        '{6, 3, 0, 0, 15420,  1, 9, 1, 12336,  0, 0, 0},      // R6 and
        '{7, 4, 7, 1, 4660,   2, 10, 0, 4660,  11, 1, 4660},  // R7 pass
        '{7, 0, 7, 0, 1,      0, 0, 0, 0,      0, 0, 0},      // R7 slot 7 untouched
        '{4, 0, 7, 1, 2,      1, 5, 0, 3,      0, 0, 0},      // R4
        '{7, 5, 0, 0, 5,      1, 12, 0, 65531, 0, 0, 0},      // R7 negate
        '{8, 6, 0, 0, 9,      0, 0, 0, 0,      0, 0, 0},      // R8 count 0
        '{7, 7, 0, 0, 255,    1, 13, 1, 65280, 0, 0, 0},      // R7 invert
        '{2, 8, 10, 0, 100,   0, 0, 0, 0,      0, 0, 0},      // R2 wraps to slot 9
        '{2, 0, 9, 1, 1,      1, 5, 0, 101,    0, 0, 0},      // R2 meets slot 9
        '{4, 0, 0, 1, 50,     0, 0, 0, 0,      0, 0, 0},      // R4 slot 0 was freed
        '{4, 0, 0, 0, 1,      1, 5, 0, 51,     0, 0, 0},      // R4
        '{8, 9, 0, 0, 41,     2, 14, 0, 42,    15, 1, 42},    // R8 count 3 acts as 2
        '{5, 1, 20, 0, 10,    0, 0, 0, 0,      0, 0, 0},      // R5 park left
        '{5, 1, 20, 0, 3,     2, 6, 1, 7,      7, 0, 7}       // R5 equal sides
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [IP_W-1:0]   in_ip = '0;
    logic [FB_W-1:0]   in_fbase = '0;
    logic              in_port = 1'b0;
    logic [DATA_W-1:0] in_value = '0;
    logic              in_ready;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [IP_W-1:0]   out_ip;
    logic [FB_W-1:0]   out_fbase;
    logic              out_port;
    logic [DATA_W-1:0] out_value;

    int checks = 0;
    int errors = 0;
    int rec_n  = 0;
    logic [27:0] rec [8];

    always #2.5 clk = ~clk;

    tok_match_unit #(
        .OUT_DEPTH(4),
        .IMEM_INIT(PROG)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ip     (in_ip),
        .in_fbase  (in_fbase),
        .in_port   (in_port),
        .in_value  (in_value),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_ip    (out_ip),
        .out_fbase (out_fbase),
        .out_port  (out_port),
        .out_value (out_value)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && rec_n < 8) begin
            rec[rec_n] = {out_ip, out_fbase, out_port, out_value};
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] tokv(int ip, int fb, int port, int val);
        return {IP_W'(ip), FB_W'(fb), port[0], DATA_W'(val)};
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic send(int ip, int fb, int port, int val);
        in_ip    = IP_W'(ip);
        in_fbase = FB_W'(fb);
        in_port  = port[0];
        in_value = DATA_W'(val);
        in_valid = 1'b1;
        forever begin
            if (in_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", 32'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);

        // Table walk: every token is taken at once (R10) and drained.
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag   = $sformatf("R%0d", VECS[i].req);
            rec_n = 0;
            send(VECS[i].ip, VECS[i].fb, VECS[i].port, VECS[i].val);
            repeat (6) @(negedge clk);
            check(rec_n == VECS[i].n, tag, $sformatf("vector %0d token count", i),
                  32'(rec_n), 32'(VECS[i].n));
            if (VECS[i].n >= 1) begin
                check(rec[0] == tokv(VECS[i].a_ip, VECS[i].fb, VECS[i].a_port, VECS[i].a_val),
                      tag, $sformatf("vector %0d first token", i), 32'(rec[0]),
                      32'(tokv(VECS[i].a_ip, VECS[i].fb, VECS[i].a_port, VECS[i].a_val)));
            end
            if (VECS[i].n >= 2) begin
                check(rec[1] == tokv(VECS[i].b_ip, VECS[i].fb, VECS[i].b_port, VECS[i].b_val),
                      tag, $sformatf("vector %0d second token", i), 32'(rec[1]),
                      32'(tokv(VECS[i].b_ip, VECS[i].fb, VECS[i].b_port, VECS[i].b_val)));
            end
        end

        // R9: back-pressure; three two-successor tokens overfill the buffer.
        out_ready = 1'b0;
        rec_n     = 0;
        send(4, 30, 0, 1);
        send(4, 30, 0, 2);
        send(4, 30, 0, 3);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R9", "in_ready while buffer full", 32'(in_ready), 0);
        check(out_valid == 1'b1, "R9", "out_valid while stalled", 32'(out_valid), 1);
        check(out_value == 16'd1, "R9", "head value held", 32'(out_value), 1);
        check(rec_n == 0, "R9", "nothing taken while stalled", 32'(rec_n), 0);
        out_ready = 1'b1;
        repeat (10) @(negedge clk);
        check(rec_n == 6, "R9", "tokens after release", 32'(rec_n), 6);
        for (int k = 0; k < 6; k++) begin
            check(rec[k] == tokv(10 + (k % 2), 30, k % 2, 1 + k / 2), "R9",
                  $sformatf("released token %0d", k), 32'(rec[k]),
                  32'(tokv(10 + (k % 2), 30, k % 2, 1 + k / 2)));
        end
        check(in_ready == 1'b1, "R10", "in_ready after drain", 32'(in_ready), 1);

        // R1: reset empties a parked slot.
        rec_n = 0;
        send(0, 40, 1, 5);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "idle after second reset",
              32'({out_valid, in_ready}), 32'b01);
        send(0, 40, 0, 6);
        repeat (5) @(negedge clk);
        check(rec_n == 0, "R1", "slot empty after reset", 32'(rec_n), 0);
        send(0, 40, 1, 1);
        repeat (5) @(negedge clk);
        check(rec_n == 1, "R1", "partner after reset count", 32'(rec_n), 1);
        check(rec[0] == tokv(5, 40, 0, 7), "R1", "partner after reset token",
              32'(rec[0]), 32'(tokv(5, 40, 0, 7)));

        summary();
        $finish;
    end

endmodule